// File: doc/BRIEF.md
# Sleep Reference Enable Duty Controller

This block drives one enable line for the voltage reference and the supply-fault monitors. While the system is awake the enable is held high. During sleep the line is normally low, but each tick from a slow duty timer opens a short on-window. In that window the reference settles and the monitors can see a brownout. The tick rate comes from its own timer and does not follow the sleep interval. The window length is a fixed number of fast-clock cycles, for example 60 µs worth at the chosen clock.

Two override bits change sleep behaviour. The hold-on bit keeps the enable high for the whole sleep, which removes the periodic pulsing. The no-pulse bit keeps the enable low for the whole sleep and ignores all ticks. Hold-on wins over no-pulse. Both bits are sampled in the first sleep cycle and held until wake. Leaving sleep drives the enable high in the same cycle and cancels any window that is running.

Top module: `srd_sleep_ref_ctrl`

## Requirements
- R1: While `sleep_i` is low, `ref_en_o` is high in that same cycle, whatever the other inputs are.
- R2: In pulse mode (both control bits clear at sleep entry), a `duty_tick_i` seen while asleep with no window open makes `ref_en_o` high for exactly `WIN_CYCLES` cycles, starting in the cycle after the tick. This also applies to a tick in the sleep entry cycle.
- R3: A tick that arrives while a window is open neither extends nor restarts that window. A tick in the window's last high cycle is also ignored.
- R4: In pulse mode, `ref_en_o` is low in every sleep cycle outside a window.
- R5: If `force_on_i` is high at sleep entry, `ref_en_o` stays high for every cycle of that sleep.
- R6: If `no_pulse_i` is high and `force_on_i` is low at sleep entry, `ref_en_o` stays low for every cycle of that sleep, and ticks have no effect.
- R7: While `force_on_i` is high, the value of `no_pulse_i` has no effect.
- R8: Control bits are taken in the first cycle of `sleep_i` high. Later changes have no effect until the next sleep entry.
- R9: A low `sleep_i` cancels an open window. On the next sleep entry no window is open until a new tick arrives.
- R10: While `rst_n` is low, no window is held and no control value is retained. `ref_en_o` then equals high when awake and equals the live `force_on_i` when asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that times the on-window |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_i | input | 1 | High while the system is asleep |
| force_on_i | input | 1 | Hold-on control: enable stays high through sleep |
| no_pulse_i | input | 1 | No-pulse control: enable stays low through sleep |
| duty_tick_i | input | 1 | Single-cycle tick from the slow duty timer |
| ref_en_o | output | 1 | Enable for the reference and supply-monitor domain |

## Verification
The bench builds the block with `WIN_CYCLES` set to 4 instead of the default 3000. This lets one test cover many complete windows, back-to-back ticks, and ticks placed in the first, middle and last window cycles. The short window also makes it cheap to reach these cases: a wake in the middle of a window, a tick in the entry cycle, control bits that flip during sleep, and a reset asserted while a window is open. Each of these is compared cycle by cycle against a behavioural model.

// File: rtl/srd_pkg.sv
package srd_pkg;

    typedef enum logic [1:0] {
        MODE_PULSE    = 2'd0,
        MODE_HOLD_ON  = 2'd1,
        MODE_HOLD_OFF = 2'd2
    } sleep_mode_e;

    // Hold-on has priority over no-pulse.
    function automatic sleep_mode_e pick_mode(input logic force_on, input logic no_pulse);
        if (force_on)
            return MODE_HOLD_ON;
        else if (no_pulse)
            return MODE_HOLD_OFF;
        else
            return MODE_PULSE;
    endfunction

endpackage

// File: rtl/srd_mode_latch.sv
module srd_mode_latch
    import srd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_i,
    input  logic        force_on_i,
    input  logic        no_pulse_i,
    output logic        entry_o,
    output sleep_mode_e mode_o
);

    typedef struct packed {
        logic        asleep;
        sleep_mode_e mode;
    } latch_state_t;

    latch_state_t state_d, state_q;
    sleep_mode_e  live_mode;

    always_comb begin
        live_mode      = pick_mode(force_on_i, no_pulse_i);
        state_d        = state_q;
        state_d.asleep = sleep_i;
        entry_o        = sleep_i && !state_q.asleep;
        if (entry_o)
            state_d.mode = live_mode;
        // The entry cycle already acts on the freshly sampled bits.
        mode_o = entry_o ? live_mode : state_q.mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.asleep <= 1'b0;
            state_q.mode   <= MODE_PULSE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/srd_window_timer.sv
module srd_window_timer #(
    parameter int WIN_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic active_o
);

    localparam int CNT_W = $clog2(WIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } timer_state_t;

    timer_state_t state_d, state_q;

    always_comb begin
        state_d  = state_q;
        active_o = (state_q.remain != '0);
        if (!run_i)
            state_d.remain = '0;
        else if (active_o)
            state_d.remain = state_q.remain - 1'b1;
        else if (tick_i)
            state_d.remain = CNT_LOAD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q.remain <= '0;
        else
            state_q <= state_d;
    end

endmodule

// File: rtl/srd_enable_mux.sv
module srd_enable_mux
    import srd_pkg::*;
(
    input  logic        sleep_i,
    input  sleep_mode_e mode_i,
    input  logic        window_i,
    output logic        en_o
);

    always_comb begin
        if (!sleep_i) begin
            en_o = 1'b1;
        end else begin
            unique case (mode_i)
                MODE_HOLD_ON:  en_o = 1'b1;
                MODE_HOLD_OFF: en_o = 1'b0;
                default:       en_o = window_i;
            endcase
        end
    end

endmodule

// File: rtl/srd_sleep_ref_ctrl.sv
module srd_sleep_ref_ctrl
    import srd_pkg::*;
#(
    parameter int WIN_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic force_on_i,
    input  logic no_pulse_i,
    input  logic duty_tick_i,
    output logic ref_en_o
);

    logic        entry;
    sleep_mode_e cur_mode;
    logic        timer_run;
    logic        window_open;

    srd_mode_latch mode_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_i),
        .force_on_i (force_on_i),
        .no_pulse_i (no_pulse_i),
        .entry_o    (entry),
        .mode_o     (cur_mode)
    );

    assign timer_run = sleep_i && (cur_mode == MODE_PULSE);

    srd_window_timer #(
        .WIN_CYCLES (WIN_CYCLES)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (timer_run),
        .tick_i   (duty_tick_i),
        .active_o (window_open)
    );

    srd_enable_mux mux_i (
        .sleep_i  (sleep_i),
        .mode_i   (cur_mode),
        .window_i (window_open),
        .en_o     (ref_en_o)
    );

    logic unused_entry;
    assign unused_entry = entry;

endmodule

// File: rtl/srd_ctrl_chk.sv
module srd_ctrl_chk #(
    parameter int WIN_CYCLES = 3000
) (
    input logic clk,
    input logic rst_n,
    input logic sleep_i,
    input logic force_on_i,
    input logic no_pulse_i,
    input logic duty_tick_i,
    input logic ref_en_o
);

    logic prev_sleep_q, ent_force_q, ent_off_q;
    int   run_q;
    logic held, pulse_now;

    assign held      = sleep_i && prev_sleep_q;
    assign pulse_now = prev_sleep_q ? (!ent_force_q && !ent_off_q)
                                    : (!force_on_i && !no_pulse_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sleep_q <= 1'b0;
            ent_force_q  <= 1'b0;
            ent_off_q    <= 1'b0;
            run_q        <= 0;
        end else begin
            prev_sleep_q <= sleep_i;
            if (sleep_i && !prev_sleep_q) begin
                ent_force_q <= force_on_i;
                ent_off_q   <= !force_on_i && no_pulse_i;
            end
            if (held && pulse_now && ref_en_o)
                run_q <= run_q + 1;
            else
                run_q <= 0;
        end
    end

    // R1
    awake_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |-> ref_en_o);
    // R5
    hold_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held && ent_force_q |-> ref_en_o);
    // R6
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held && ent_off_q |-> !ref_en_o);
    // R7
    entry_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i && !prev_sleep_q && force_on_i |-> ref_en_o);
    // R2
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i && pulse_now && duty_tick_i && !ref_en_o |=> ref_en_o || !sleep_i);
    // R4
    pulse_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held && pulse_now && $rose(ref_en_o) |-> $past(duty_tick_i));
    // R3
    window_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= WIN_CYCLES);
    // R2
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held && pulse_now && $fell(ref_en_o) |-> run_q == WIN_CYCLES);

endmodule

bind srd_sleep_ref_ctrl srd_ctrl_chk #(
    .WIN_CYCLES (WIN_CYCLES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .force_on_i  (force_on_i),
    .no_pulse_i  (no_pulse_i),
    .duty_tick_i (duty_tick_i),
    .ref_en_o    (ref_en_o)
);

// File: tb/srd_sleep_ref_ctrl_tb_top.sv
module srd_sleep_ref_ctrl_tb_top;

    localparam int WIN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_i = 1'b0, force_on_i = 1'b0, no_pulse_i = 1'b0, duty_tick_i = 1'b0;
    logic ref_en_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural model state: 0 pulse, 1 hold-on, 2 hold-off
    bit m_prev = 0;
    int m_mode = 0;
    int m_remain = 0;

    always #10 clk = ~clk;

    srd_sleep_ref_ctrl #(.WIN_CYCLES(WIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .force_on_i(force_on_i),
        .no_pulse_i(no_pulse_i), .duty_tick_i(duty_tick_i), .ref_en_o(ref_en_o)
    );

    function automatic int live_mode();
        if (force_on_i) return 1;
        if (no_pulse_i) return 2;
        return 0;
    endfunction

    function automatic int eff_mode();
        if (sleep_i && !m_prev) return live_mode();
        return m_mode;
    endfunction

    function automatic logic model_en();
        if (!sleep_i) return 1'b1;
        case (eff_mode())
            1: return 1'b1;
            2: return 1'b0;
            default: return (m_remain > 0);
        endcase
    endfunction

    task automatic step(input logic rs, input logic s, input logic f,
                        input logic n, input logic t, input string req);
        logic exp_en;
        int em;
        @(negedge clk);
        rst_n = rs; sleep_i = s; force_on_i = f; no_pulse_i = n; duty_tick_i = t;
        #5;
        exp_en = model_en();
        checks++;
        if (ref_en_o !== exp_en) begin
            failures++;
            $display("FAIL %s: ref_en_o actual=%b expected=%b at %0t", req, ref_en_o, exp_en, $time);
        end
        @(posedge clk);
        em = eff_mode();
        if (!rst_n) begin
            m_prev = 0; m_mode = 0; m_remain = 0;
        end else if (!sleep_i) begin
            m_prev = 0; m_remain = 0;
        end else begin
            m_mode = em;
            m_prev = 1;
            if (em != 0) m_remain = 0;
            else if (m_remain > 0) m_remain--;
            else if (duty_tick_i) m_remain = WIN;
        end
    endtask

    task automatic idle(input int k, input logic s, input logic f, input logic n, input string req);
        for (int i = 0; i < k; i++) step(1, s, f, n, 0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        step(0, 0, 0, 0, 0, "R10");
        step(0, 1, 0, 0, 1, "R10");
        step(0, 1, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 0, "R10");
        // R1 awake, ticks and controls toggling
        step(1, 0, 0, 0, 1, "R1");
        step(1, 0, 1, 1, 1, "R1");
        step(1, 0, 0, 1, 0, "R1");
        // R4 pulse sleep, no ticks
        idle(5, 1, 0, 0, "R4");
        // R2 tick opens window
        step(1, 1, 0, 0, 1, "R2");
        idle(WIN + 2, 1, 0, 0, "R2");
        // R3 ticks inside window (first, middle, last cycle)
        step(1, 1, 0, 0, 1, "R3");
        step(1, 1, 0, 0, 1, "R3");
        step(1, 1, 0, 0, 0, "R3");
        step(1, 1, 0, 0, 1, "R3");
        step(1, 1, 0, 0, 1, "R3");
        idle(WIN + 2, 1, 0, 0, "R3");
        // R2 back-to-back ticks every cycle
        for (int i = 0; i < 3 * WIN; i++) step(1, 1, 0, 0, 1, "R2");
        idle(3, 1, 0, 0, "R4");
        // R9 wake mid-window, re-enter
        step(1, 1, 0, 0, 1, "R9");
        step(1, 1, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, "R9");
        idle(4, 1, 0, 0, "R9");
        // R2 tick in entry cycle
        step(1, 0, 0, 0, 0, "R1");
        step(1, 1, 0, 0, 1, "R2");
        idle(WIN + 2, 1, 0, 0, "R2");
        // R8 controls set during pulse sleep are ignored
        step(1, 1, 1, 0, 0, "R8");
        step(1, 1, 0, 1, 1, "R8");
        idle(WIN + 2, 1, 0, 1, "R8");
        step(1, 0, 0, 0, 0, "R1");
        // R5 and R7 hold-on with no-pulse toggling and ticks
        step(1, 1, 1, 1, 1, "R7");
        step(1, 1, 1, 0, 1, "R5");
        step(1, 1, 0, 1, 0, "R8");
        step(1, 1, 0, 0, 1, "R8");
        idle(6, 1, 0, 0, "R5");
        step(1, 0, 0, 0, 0, "R1");
        // R6 no-pulse, ticks ignored, force set later ignored
        step(1, 1, 0, 1, 1, "R6");
        step(1, 1, 0, 1, 1, "R6");
        step(1, 1, 1, 0, 1, "R8");
        step(1, 1, 0, 0, 1, "R6");
        idle(WIN + 2, 1, 0, 0, "R6");
        step(1, 0, 0, 0, 0, "R1");
        // R10 reset during open window
        step(1, 1, 0, 0, 1, "R10");
        step(1, 1, 0, 0, 0, "R10");
        step(0, 1, 0, 0, 0, "R10");
        step(0, 1, 0, 0, 0, "R10");
        step(1, 1, 0, 0, 0, "R10");
        idle(WIN + 1, 1, 0, 0, "R10");
        step(1, 0, 0, 0, 0, "R1");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule